// File: doc/BRIEF.md
# MSI Doorbell Interrupt Aggregator

This block receives message-signalled interrupts for a PCIe root port and turns them into per-group level interrupt lines for the host. The root port forwards every inbound posted write on a dedicated inbound port. A write that lands on the doorbell offset carries a vector number in its data. The block records that vector as a pending bit. The 32 vectors are interleaved over 8 groups of 4 bits. Vector v is held in group v mod 8 at bit v div 8, so vectors 0, 8, 16 and 24 share group 0.

Host software reaches the block through a plain 32-bit register port. Each group has three registers:

- a pending register, which is cleared by writing 1 to a bit;
- an enable-set register;
- an enable-clear register.

A group's interrupt line stays high while any of its bits is both pending and enabled. Software finishes servicing a group by writing that group's index plus 4 to an end-of-interrupt register. That write forces the line low for one cycle. The low cycle gives the interrupt controller a fresh edge to see if work is still pending.

Top module: `msi_doorbell_agg`

## Requirements
- R1: While reset is active, and after it is released, every pending bit, every enable bit and every interrupt line is 0.
- R2: An inbound write to offset 0x054 with data v below 32 sets pending bit v div 8 of group v mod 8. The pending bits of group n read back in bits [3:0] at offset 0x104 + 0x10*n.
- R3: An inbound write is ignored if its data is 32 or more, or if it goes to any offset other than 0x054.
- R4: A software write to a group's pending register clears each bit written as 1. Bits written as 0 keep their value.
- R5: Writing 1s to offset 0x108 + 0x10*n sets enable bits of group n, and writing 1s to 0x10C + 0x10*n clears them. Bits written as 0 keep their value. Reading either offset returns the enable mask in bits [3:0].
- R6: A pending register reads the raw pending bits whether or not they are enabled.
- R7: irq_o[n] is high exactly when group n has at least one bit that is both pending and enabled, except in the cycle after an end-of-interrupt write for group n.
- R8: A software write of value n+4 to offset 0x050 drives irq_o[n] low for the one cycle after the write. The line then follows R7 again. Other values, and other groups, are not affected.
- R9: If an inbound doorbell and a software clear hit the same pending bit in the same cycle, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr | input | 1 | Software register write strobe |
| sw_addr | input | 12 | Software byte offset, used for reads and writes |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Read data for sw_addr (combinational) |
| ib_wr | input | 1 | Inbound posted-write strobe from the root port |
| ib_addr | input | 12 | Inbound write byte offset |
| ib_data | input | 32 | Inbound write data (vector number) |
| irq_o | output | 8 | One level interrupt per group |

## Verification
The bench rings vectors that land in different groups and bit positions. A design that mapped vector v to group v div 8 instead of v mod 8 would show the bit in the wrong register. It rings with the value 40, whose low five bits name a valid vector; a design that truncates the data instead of rejecting it sets a stray pending bit. It checks the end-of-interrupt gap: a design without the gap keeps the line high, and one that decodes the group index wrongly drops the wrong line or drops it for too long. Finally it lands a doorbell and a clear on the same bit in the same cycle; a design with the wrong priority loses the new interrupt.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  // Fixed software-visible offsets
  localparam logic [ADDR_W-1:0] EOI_OFS  = 12'h050;
  localparam logic [ADDR_W-1:0] DB_OFS   = 12'h054;
  localparam logic [3:0]        GRP_PAGE = 4'h1;    // groups live at 0x1n_
  localparam logic [3:0]        SUB_STAT = 4'h4;
  localparam logic [3:0]        SUB_ENS  = 4'h8;
  localparam logic [3:0]        SUB_ENC  = 4'hC;
  localparam int unsigned       EOI_BIAS = 4;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_STAT,
    RK_ENS,
    RK_ENC
  } reg_kind_e;
endpackage

// File: rtl/msi_agg_decode.sv
module msi_agg_decode
  import msi_agg_pkg::*;
#(
  parameter int unsigned GROUPS = 8,
  parameter int unsigned BITS   = 4
) (
  input  logic                          sw_wr,
  input  logic [ADDR_W-1:0]             sw_addr,
  input  logic [DATA_W-1:0]             sw_wdata,
  input  logic                          ib_wr,
  input  logic [ADDR_W-1:0]             ib_addr,
  input  logic [DATA_W-1:0]             ib_data,
  output reg_kind_e                     kind,
  output logic [GROUPS-1:0]             grp_hit,
  output logic [GROUPS-1:0]             eoi_hit,
  output logic [GROUPS-1:0][BITS-1:0]   ring
);
  localparam int unsigned NVEC = GROUPS * BITS;
  localparam int unsigned VW   = $clog2(NVEC);

  logic       in_page;
  logic [3:0] grp_idx;
  logic [3:0] sub;
  logic       eoi_wr;
  logic       db_ok;

  assign in_page = (sw_addr[11:8] == GRP_PAGE);
  assign grp_idx = sw_addr[7:4];
  assign sub     = sw_addr[3:0];
  assign eoi_wr  = sw_wr && (sw_addr == EOI_OFS);
  assign db_ok   = ib_wr && (ib_addr == DB_OFS) && (ib_data < DATA_W'(NVEC));

  always_comb begin
    kind = RK_NONE;
    if (in_page && (32'(grp_idx) < GROUPS)) begin
      case (sub)
        SUB_STAT: kind = RK_STAT;
        SUB_ENS:  kind = RK_ENS;
        SUB_ENC:  kind = RK_ENC;
        default:  kind = RK_NONE;
      endcase
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_hit[g] = in_page && (grp_idx == 4'(g));
    assign eoi_hit[g] = eoi_wr && (sw_wdata == DATA_W'(g + EOI_BIAS));
    for (genvar b = 0; b < BITS; b++) begin : g_bit
      // interleaved: vector = bit*GROUPS + group
      assign ring[g][b] = db_ok && (ib_data[VW-1:0] == VW'(b * GROUPS + g));
    end
  end
endmodule

// File: rtl/msi_agg_group.sv
module msi_agg_group #(
  parameter int unsigned BITS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] ring,
  input  logic [BITS-1:0] stat_clr,
  input  logic [BITS-1:0] en_set,
  input  logic [BITS-1:0] en_clr,
  input  logic            eoi,
  output logic [BITS-1:0] pend,
  output logic [BITS-1:0] en,
  output logic            irq
);
  logic [BITS-1:0] pend_d, en_d;
  logic            gap_q, gap_d;
  logic            pend_ce, en_ce;

  always_comb begin
    pend_ce = |ring || |stat_clr;
    en_ce   = |en_set || |en_clr;
    pend_d  = (pend & ~stat_clr) | ring;   // a new doorbell beats a clear
    en_d    = (en | en_set) & ~en_clr;
    gap_d   = eoi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      en    <= '0;
      gap_q <= 1'b0;
    end else begin
      if (pend_ce) pend <= pend_d;
      if (en_ce)   en   <= en_d;
      gap_q <= gap_d;
    end
  end

  assign irq = (|(pend & en)) && !gap_q;
endmodule

// File: rtl/msi_doorbell_agg.sv
module msi_doorbell_agg
  import msi_agg_pkg::*;
#(
  parameter int unsigned GROUPS = 8,
  parameter int unsigned BITS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [11:0]       sw_addr,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  input  logic              ib_wr,
  input  logic [11:0]       ib_addr,
  input  logic [31:0]       ib_data,
  output logic [GROUPS-1:0] irq_o
);
  logic [1:0] rst_sync;
  logic       rst_sn;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  reg_kind_e                   kind;
  logic [GROUPS-1:0]           grp_hit, eoi_hit;
  logic [GROUPS-1:0][BITS-1:0] ring, pend_q, en_q;

  msi_agg_decode #(.GROUPS(GROUPS), .BITS(BITS)) u_dec (
    .sw_wr   (sw_wr),
    .sw_addr (sw_addr),
    .sw_wdata(sw_wdata),
    .ib_wr   (ib_wr),
    .ib_addr (ib_addr),
    .ib_data (ib_data),
    .kind    (kind),
    .grp_hit (grp_hit),
    .eoi_hit (eoi_hit),
    .ring    (ring)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic          wr_here;
    logic [BITS-1:0] clr_v, ens_v, enc_v;
    assign wr_here = sw_wr && grp_hit[g];
    assign clr_v = (wr_here && kind == RK_STAT) ? sw_wdata[BITS-1:0] : '0;
    assign ens_v = (wr_here && kind == RK_ENS)  ? sw_wdata[BITS-1:0] : '0;
    assign enc_v = (wr_here && kind == RK_ENC)  ? sw_wdata[BITS-1:0] : '0;

    msi_agg_group #(.BITS(BITS)) u_grp (
      .clk     (clk),
      .rst_n   (rst_sn),
      .ring    (ring[g]),
      .stat_clr(clr_v),
      .en_set  (ens_v),
      .en_clr  (enc_v),
      .eoi     (eoi_hit[g]),
      .pend    (pend_q[g]),
      .en      (en_q[g]),
      .irq     (irq_o[g])
    );
  end

  always_comb begin
    sw_rdata = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (grp_hit[g]) begin
        case (kind)
          RK_STAT:        sw_rdata[BITS-1:0] = pend_q[g];
          RK_ENS, RK_ENC: sw_rdata[BITS-1:0] = en_q[g];
          default:        sw_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/msi_agg_checker.sv
module msi_agg_checker #(
  parameter int unsigned GROUPS = 8,
  parameter int unsigned BITS   = 4
) (
  input logic                        clk,
  input logic                        rst_sn,
  input logic                        sw_wr,
  input logic [11:0]                 sw_addr,
  input logic [31:0]                 sw_wdata,
  input logic                        ib_wr,
  input logic [11:0]                 ib_addr,
  input logic [31:0]                 ib_data,
  input logic [GROUPS-1:0][BITS-1:0] pend_q,
  input logic [GROUPS-1:0][BITS-1:0] en_q,
  input logic [GROUPS-1:0]           irq_o
);
  // R1: state held clear while the internal reset is active
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_sn |-> (pend_q == '0 && en_q == '0 && irq_o == '0));

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_sn)
      irq_o[g] |-> (|(pend_q[g] & en_q[g])));
    p_eoi_gap_r8: assert property (@(posedge clk) disable iff (!rst_sn)
      (sw_wr && sw_addr == 12'h050 && sw_wdata == 32'(g + 4)) |=> !irq_o[g]);

    for (genvar b = 0; b < BITS; b++) begin : g_b
      logic ring_b, clr_b;
      assign ring_b = ib_wr && ib_addr == 12'h054 && ib_data == 32'(b * GROUPS + g);
      assign clr_b  = sw_wr && sw_addr == 12'(12'h104 + 16 * g) && sw_wdata[b];
      p_ring_sets_r2: assert property (@(posedge clk) disable iff (!rst_sn)
        ring_b |=> pend_q[g][b]);
      p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_sn)
        (clr_b && !ring_b) |=> !pend_q[g][b]);
      p_collide_r9: assert property (@(posedge clk) disable iff (!rst_sn)
        (clr_b && ring_b) |=> pend_q[g][b]);
      p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_sn)
        (sw_wr && sw_addr == 12'(12'h108 + 16 * g) && sw_wdata[b]) |=> en_q[g][b]);
      p_en_clr_r5: assert property (@(posedge clk) disable iff (!rst_sn)
        (sw_wr && sw_addr == 12'(12'h10C + 16 * g) && sw_wdata[b]) |=> !en_q[g][b]);
    end
  end
endmodule

bind msi_doorbell_agg msi_agg_checker #(.GROUPS(GROUPS), .BITS(BITS)) u_chk (
  .clk     (clk),
  .rst_sn  (rst_sn),
  .sw_wr   (sw_wr),
  .sw_addr (sw_addr),
  .sw_wdata(sw_wdata),
  .ib_wr   (ib_wr),
  .ib_addr (ib_addr),
  .ib_data (ib_data),
  .pend_q  (pend_q),
  .en_q    (en_q),
  .irq_o   (irq_o)
);

// File: tb/msi_doorbell_agg_test.sv
module msi_doorbell_agg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_wr;
  logic [11:0] sw_addr;
  logic [31:0] sw_wdata;
  logic [31:0] sw_rdata;
  logic        ib_wr;
  logic [11:0] ib_addr;
  logic [31:0] ib_data;
  logic [7:0]  irq_o;

  always #5 clk = ~clk;

  msi_doorbell_agg uut (
    .clk(clk), .rst_n(rst_n),
    .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .ib_wr(ib_wr), .ib_addr(ib_addr), .ib_data(ib_data), .irq_o(irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  function automatic logic [11:0] stat_a(int g); return 12'(12'h104 + 16 * g); endfunction
  function automatic logic [11:0] ens_a(int g);  return 12'(12'h108 + 16 * g); endfunction
  function automatic logic [11:0] enc_a(int g);  return 12'(12'h10C + 16 * g); endfunction

  // monitor: compares queued expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = it.is_irq ? {24'h0, irq_o} : sw_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic exp_rd(logic [11:0] a, logic [31:0] e, string req);
    item_t it;
    sw_addr = a;
    it.is_irq = 0; it.exp = e; it.req = req;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic exp_irq(logic [7:0] e, string req);
    item_t it;
    it.is_irq = 1; it.exp = {24'h0, e}; it.req = req;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic cyc(bit s, logic [11:0] sa, logic [31:0] sd,
                     bit i, logic [11:0] ia, logic [31:0] id);
    @(posedge clk); #1;
    sw_wr = s; sw_addr = sa; sw_wdata = sd;
    ib_wr = i; ib_addr = ia; ib_data = id;
    @(posedge clk); #1;
    sw_wr = 0; ib_wr = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d); cyc(1, a, d, 0, 12'h0, 32'h0); endtask
  task automatic ring(logic [31:0] v); cyc(0, 12'h0, 32'h0, 1, 12'h054, v); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sw_wr = 0; sw_addr = 0; sw_wdata = 0;
    ib_wr = 0; ib_addr = 0; ib_data = 0;
    repeat (3) @(posedge clk); #1;
    exp_irq(8'h00, "R1 irq in reset");
    rst_n = 1;
    repeat (4) @(posedge clk); #1;
    exp_rd(stat_a(0), 32'h0, "R1 pending after reset");
    exp_rd(ens_a(3), 32'h0, "R1 enable after reset");
    exp_irq(8'h00, "R1 irq after reset");

    // R2 / R6: interleaved mapping, raw read
    ring(17);
    exp_rd(stat_a(1), 32'h4, "R2 vector 17 -> group1 bit2");
    exp_rd(stat_a(1), 32'h4, "R6 raw pending while disabled");
    ring(24);
    exp_rd(stat_a(0), 32'h8, "R2 vector 24 -> group0 bit3");

    // R3: out-of-range value and wrong offset
    ring(40);
    exp_rd(stat_a(0), 32'h8, "R3 value 40 ignored");
    cyc(0, 12'h0, 32'h0, 1, 12'h058, 32'd5);
    exp_rd(stat_a(5), 32'h0, "R3 wrong offset ignored");

    // R5 / R7
    wr(ens_a(1), 32'h4);
    exp_rd(ens_a(1), 32'h4, "R5 enable set readback");
    exp_rd(enc_a(1), 32'h4, "R5 enable via clear offset");
    exp_irq(8'h02, "R7 group1 enabled pending");
    wr(ens_a(1), 32'h1);
    exp_rd(ens_a(1), 32'h5, "R5 set leaves others");
    wr(enc_a(1), 32'h4);
    exp_rd(ens_a(1), 32'h1, "R5 clear one bit");
    exp_irq(8'h00, "R7 masked pending no irq");

    // R4
    wr(ens_a(1), 32'h4);
    wr(stat_a(1), 32'h0);
    exp_rd(stat_a(1), 32'h4, "R4 zero write keeps bit");
    wr(stat_a(1), 32'h4);
    exp_rd(stat_a(1), 32'h0, "R4 one write clears bit");
    exp_irq(8'h00, "R7 cleared pending drops irq");

    // R8: EOI gap
    ring(2);
    wr(ens_a(2), 32'h1);
    exp_irq(8'h04, "R7 group2 asserted");
    wr(12'h050, 32'd6);
    exp_irq(8'h00, "R8 gap cycle after EOI");
    exp_irq(8'h04, "R8 reassert after gap");
    wr(12'h050, 32'd7);
    exp_irq(8'h04, "R8 other group EOI no effect");
    wr(12'h050, 32'd3);
    exp_irq(8'h04, "R8 non-group EOI value no effect");

    // R9: collision
    cyc(1, stat_a(2), 32'h1, 1, 12'h054, 32'd2);
    exp_rd(stat_a(2), 32'h1, "R9 doorbell wins over clear");
    wr(stat_a(2), 32'h1);
    exp_rd(stat_a(2), 32'h0, "R4 clear without doorbell");

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule